// File: doc/BRIEF.md
# Dual-Resolution Interval Timer Pair

This block holds two independent interval timers driven from one master clock. Each timer has its own prescaler. The fine timer steps once every 32 master clocks and has a 10-bit period value. The coarse timer steps once every 512 master clocks and has an 8-bit period value. A timer counts upward from its programmed period. When it passes its all-ones value it overflows: it reloads the current period and sets a sticky flag. Software starts and stops the timers and clears the flags through a control register. It reads the flags through a status register. A level output is high while either flag is set.

All access goes through a plain 8-bit register port with an address, write data, a write strobe and a read strobe. The register addresses are as follows:
- 0: fine period, upper 8 bits.
- 1: fine period, lower 2 bits.
- 2: coarse period.
- 3: control.
- 4: status.

Writes to the status register do nothing. The flags leave only through the clear bits of the control register.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, every register at addresses 0 to 4 reads 0, both timers are stopped and `irq` is 0.
- R2: The fine period is written as bits [9:2] at address 0 and bits [1:0] at address 1 (write-data bits [1:0]). Address 1 reads back those two bits with bits [7:2] as 0. The coarse period reads back unchanged at address 2.
- R3: A write to control (address 3) with bit 0 set starts a stopped fine timer from its period P. Its flag (status bit 0) reads 1 exactly 32*(1024-P) clock edges after the start edge, and not one edge earlier.
- R4: A write to control with bit 1 set starts a stopped coarse timer from its period Q. Its flag (status bit 1) reads 1 exactly 512*(256-Q) edges after the start edge. The other timer's flag does not change.
- R5: On overflow a running timer reloads from the period programmed at that moment. A period written mid-run therefore governs the interval that begins at the next overflow, and the intervals follow one another without gaps.
- R6: A write to the status register (address 4) leaves both flags unchanged, whatever the data.
- R7: Control bit 4 clears the fine flag and control bit 5 clears the coarse flag. Both are one-shot and read back as 0; control reads back only its run bits 0 and 1.
- R8: If an overflow and a clear of the same flag fall on the same edge, the flag is 1 afterwards.
- R9: Writing control with a run bit at 0 stops that timer, and no flag is set while it is stopped. Starting it again reloads the period and restarts the prescaler, so the full interval is timed again. Writing a run bit of 1 to a running timer does not restart it.
- R10: `irq` is 1 exactly while at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; read data is 0 when low |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | High while any overflow flag is set |

## Verification
A wrong prescaler or counter value shows as a flag that rises one or more edges early or late. The bench samples status on the edge before and the edge of each predicted overflow, so the error appears within one timer interval. A missed reload or a stale period shows on the second interval after a start or after a period change. A wrong priority between clear and overflow shows as a status read of 0 on the very next cycle.

// File: rtl/xtmr_pkg.sv
// Package: shared constants for the dual interval timer.
// Assumes an 8-bit register port with five decoded addresses.
package xtmr_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_A_HI  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_A_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_B_PER = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd4;

    localparam int CTL_RUN_BASE = 0;   // bit0 fine run, bit1 coarse run
    localparam int CTL_CLR_BASE = 4;   // bit4 fine clear, bit5 coarse clear
    localparam int NUM_TMR      = 2;
endpackage

// File: rtl/xtmr_unit.sv
// Module: one prescaled up-counting timer.
// Assumes restart is only raised while run is low; period is sampled at
// restart and again at every overflow. ovf is a one-cycle pulse.
module xtmr_unit #(
    parameter int PER_W    = 10,
    parameter int PRE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             ovf
);
    logic [PRE_LOG2-1:0] presc;
    logic [PER_W-1:0]    cnt;
    logic                presc_full;
    logic                cnt_full;

    // Terminal-count detection for prescaler and main counter
    always_comb begin
        presc_full = &presc;
        cnt_full   = &cnt;
        ovf        = run && presc_full && cnt_full;
    end

    // Prescaler and counter advance, reload on restart or overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc <= '0;
            cnt   <= '0;
        end else if (restart) begin
            presc <= '0;
            cnt   <= period;
        end else if (run) begin
            presc <= presc + 1'b1;
            if (presc_full) begin
                cnt <= cnt_full ? period : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xtmr_regs.sv
// Module: register file, run control and sticky flags for both timers.
// Assumes PA_W > DATA_W and PB_W <= DATA_W. Overflow outranks clear.
module xtmr_regs
    import xtmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PA_W   = 10,
    parameter int PB_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_TMR-1:0] ovf,
    output logic [PA_W-1:0]   per_a,
    output logic [PB_W-1:0]   per_b,
    output logic [NUM_TMR-1:0] run,
    output logic [NUM_TMR-1:0] restart,
    output logic [NUM_TMR-1:0] flag,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PA_LO_W = PA_W - DATA_W;

    logic [DATA_W-1:0]  pa_hi;
    logic [PA_LO_W-1:0] pa_lo;
    logic [PB_W-1:0]    pb;
    logic               ctl_wr;
    logic [NUM_TMR-1:0] start_req;
    logic [NUM_TMR-1:0] clr_req;

    // Control write decode into run requests and one-shot clears
    always_comb begin
        ctl_wr = wr_en && (addr == ADDR_CTRL);
        for (int i = 0; i < NUM_TMR; i++) begin
            start_req[i] = ctl_wr && wr_data[CTL_RUN_BASE + i];
            clr_req[i]   = ctl_wr && wr_data[CTL_CLR_BASE + i];
            restart[i]   = start_req[i] && !run[i];
        end
        per_a = {pa_hi, pa_lo};
        per_b = pb;
    end

    // Period and run-bit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_hi <= '0;
            pa_lo <= '0;
            pb    <= '0;
            run   <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_A_HI:  pa_hi <= wr_data;
                ADDR_A_LO:  pa_lo <= wr_data[PA_LO_W-1:0];
                ADDR_B_PER: pb    <= wr_data[PB_W-1:0];
                ADDR_CTRL:  run   <= start_req;
                default:    ;
            endcase
        end
    end

    // One sticky flag per timer; overflow outranks clear
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flag[g] <= 1'b0;
            else if (ovf[g])     flag[g] <= 1'b1;
            else if (clr_req[g]) flag[g] <= 1'b0;
        end
    end

    // Read mux, gated by the read strobe
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                ADDR_A_HI:  rd_data = pa_hi;
                ADDR_A_LO:  rd_data = DATA_W'(pa_lo);
                ADDR_B_PER: rd_data = DATA_W'(pb);
                ADDR_CTRL:  rd_data = DATA_W'(run);
                ADDR_STAT:  rd_data = DATA_W'(flag);
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
// Module: top of the dual interval timer; fine and coarse timers plus
// the register file. Assumes one synchronous clock domain.
module dual_interval_timer
    import xtmr_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PA_W       = 10,
    parameter int PB_W       = 8,
    parameter int PRE_A_LOG2 = 5,
    parameter int PRE_B_LOG2 = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [PA_W-1:0]    per_a;
    logic [PB_W-1:0]    per_b;
    logic [NUM_TMR-1:0] run_vec;
    logic [NUM_TMR-1:0] restart_vec;
    logic [NUM_TMR-1:0] flag_vec;
    logic [NUM_TMR-1:0] ovf_vec;

    xtmr_regs #(.DATA_W(DATA_W), .PA_W(PA_W), .PB_W(PB_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .ovf(ovf_vec),
        .per_a(per_a), .per_b(per_b), .run(run_vec),
        .restart(restart_vec), .flag(flag_vec), .rd_data(rd_data)
    );

    xtmr_unit #(.PER_W(PA_W), .PRE_LOG2(PRE_A_LOG2)) fine_i (
        .clk(clk), .rst_n(rst_n), .run(run_vec[0]),
        .restart(restart_vec[0]), .period(per_a), .ovf(ovf_vec[0])
    );

    xtmr_unit #(.PER_W(PB_W), .PRE_LOG2(PRE_B_LOG2)) coarse_i (
        .clk(clk), .rst_n(rst_n), .run(run_vec[1]),
        .restart(restart_vec[1]), .period(per_b), .ovf(ovf_vec[1])
    );

    // Interrupt-style level output
    always_comb irq = |flag_vec;
endmodule

// File: rtl/dual_interval_timer_chk.sv
// Module: property checker bound to dual_interval_timer.
// Assumes flags are driven by the register file and overflow pulses by the units.
module dual_interval_timer_chk
    import xtmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic              flag_a,
    input logic              flag_b,
    input logic              ovf_a,
    input logic              ovf_b,
    input logic              run_a,
    input logic              run_b
);
    p_status_wr_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT && !ovf_a) |=> $stable(flag_a));
    p_status_wr_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT && !ovf_b) |=> $stable(flag_b));
    p_clear_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTRL && wr_data[CTL_CLR_BASE] && !ovf_a) |=> !flag_a);
    p_ovf_wins_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_a |=> flag_a);
    p_ovf_wins_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_b |=> flag_b);
    p_stopped_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_a |-> !ovf_a);
    p_stopped_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_b |-> !ovf_b);
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(flag_a) || $rose(flag_b)));
endmodule

bind dual_interval_timer dual_interval_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irq(irq), .flag_a(flag_vec[0]), .flag_b(flag_vec[1]),
    .ovf_a(ovf_vec[0]), .ovf_b(ovf_vec[1]),
    .run_a(run_vec[0]), .run_b(run_vec[1])
);

// File: tb/dual_interval_timer_tb_top.sv
// Bench: directed corner cases plus seeded random periods for both timers.
module dual_interval_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    dual_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int fine_ticks(int p);
        return 32 * (1024 - p);
    endfunction

    function automatic int coarse_ticks(int p);
        return 512 * (256 - p);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at edge %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wr(int a, int d);
        addr = 3'(a);
        wr_data = 8'(d);
        wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(int a, output int v);
        addr = 3'(a);
        rd_en = 1'b1;
        #1 v = int'(rd_data);
        rd_en = 1'b0;
    endtask

    task automatic goto_edge(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic chk_stat(string req, int exp);
        int v;
        rd(4, v);
        chk(req, v, exp);
    endtask

    task automatic set_fine(int p);
        wr(0, p >> 2);
        wr(1, (p & 3) | 8'hFC);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v, e, n, n2, p;
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk("R1 reg after reset", v, 0);
        end
        chk("R1 irq after reset", int'(irq), 0);

        // R2: period readback with random values
        for (int i = 0; i < 6; i++) begin
            int hi, lo, pb;
            hi = $urandom_range(0, 255);
            lo = $urandom_range(0, 3);
            pb = $urandom_range(0, 255);
            wr(0, hi);
            wr(1, lo | 8'hFC);
            wr(2, pb);
            rd(0, v); chk("R2 fine high", v, hi);
            rd(1, v); chk("R2 fine low", v, lo);
            rd(2, v); chk("R2 coarse", v, pb);
        end

        // R3/R10: fine timer first overflow, P=1023
        set_fine(1023);
        n = fine_ticks(1023);
        wr(3, 8'h01);
        e = cyc;
        goto_edge(e + n - 1);
        chk_stat("R3 fine flag one edge early", 0);
        chk("R10 irq low before overflow", int'(irq), 0);
        goto_edge(e + n);
        chk_stat("R3 fine flag at overflow", 1);
        chk("R10 irq high with flag", int'(irq), 1);

        // R7: clear pulse, control readback
        wr(3, 8'h11);
        chk_stat("R7 fine flag cleared", 0);
        rd(3, v);
        chk("R7 control reads run bits only", v, 1);

        // R8: clear on the overflow edge loses
        goto_edge(e + 2 * n - 1);
        chk_stat("R5 no early second overflow", 0);
        wr(3, 8'h11);
        chk_stat("R8 overflow wins over clear", 1);

        // R6: status writes are ignored
        wr(4, 8'h00);
        chk_stat("R6 status write zero keeps flag", 1);
        wr(3, 8'h11);
        chk_stat("R7 clear after R6", 0);
        chk("R10 irq low after clear", int'(irq), 0);
        wr(4, 8'hFF);
        chk_stat("R6 status write ones sets nothing", 0);

        // R5: period change mid-run applies at next reload
        set_fine(1020);
        n2 = fine_ticks(1020);
        goto_edge(e + 3 * n);
        chk_stat("R5 overflow with old period", 1);
        wr(3, 8'h11);
        goto_edge(e + 3 * n + n2 - 1);
        chk_stat("R5 new period not early", 0);
        goto_edge(e + 3 * n + n2);
        chk_stat("R5 new period overflow", 1);

        // R9: stop, nothing while stopped, restart times full interval
        wr(3, 8'h10);
        e = cyc;
        goto_edge(e + 3 * n2);
        chk_stat("R9 no flag while stopped", 0);
        rd(3, v);
        chk("R9 run bit reads 0", v, 0);
        wr(3, 8'h01);
        e = cyc;
        goto_edge(e + 40);
        wr(3, 8'h01);
        goto_edge(e + n2 - 1);
        chk_stat("R9 restart not early, rerun ignored", 0);
        goto_edge(e + n2);
        chk_stat("R9 restart full interval", 1);
        wr(3, 8'h10);

        // R4: coarse timer, Q=255
        wr(2, 255);
        n = coarse_ticks(255);
        wr(3, 8'h02);
        e = cyc;
        goto_edge(e + n - 1);
        chk_stat("R4 coarse not early", 0);
        goto_edge(e + n);
        chk_stat("R4 coarse flag only", 2);
        chk("R10 irq from coarse", int'(irq), 1);
        wr(3, 8'h22);
        chk_stat("R7 coarse cleared", 0);
        goto_edge(e + 2 * n - 1);
        wr(3, 8'h22);
        chk_stat("R8 coarse overflow wins", 2);
        wr(3, 8'h20);

        // R3/R5: random fine periods, two intervals each
        for (int i = 0; i < 5; i++) begin
            p = $urandom_range(990, 1023);
            n = fine_ticks(p);
            set_fine(p);
            wr(3, 8'h11);
            e = cyc;
            goto_edge(e + n - 1);
            chk_stat("R3 random fine not early", 0);
            goto_edge(e + n);
            chk_stat("R3 random fine overflow", 1);
            wr(3, 8'h11);
            goto_edge(e + 2 * n - 1);
            chk_stat("R5 random fine second not early", 0);
            goto_edge(e + 2 * n);
            chk_stat("R5 random fine second overflow", 1);
            wr(3, 8'h10);
        end

        // R4/R5: random coarse periods, two intervals each
        for (int i = 0; i < 3; i++) begin
            p = $urandom_range(248, 255);
            n = coarse_ticks(p);
            wr(2, p);
            wr(3, 8'h22);
            e = cyc;
            goto_edge(e + n - 1);
            chk_stat("R4 random coarse not early", 0);
            goto_edge(e + n);
            chk_stat("R4 random coarse overflow", 2);
            wr(3, 8'h22);
            goto_edge(e + 2 * n - 1);
            chk_stat("R5 random coarse second not early", 0);
            goto_edge(e + 2 * n);
            chk_stat("R5 random coarse second overflow", 2);
            wr(3, 8'h20);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule